// File: doc/BRIEF.md
# Top-Relative Register Stack with Slot Tags

This block is a small bank of data registers that is addressed through a rotating top pointer rather than by fixed physical number. A command names a register as an offset from the current top: offset 0 is the top, offset i is the register i places below it. Pushing moves the pointer down by one, modulo the bank size, and popping moves it up. Each physical register carries a two-bit tag that says whether it is empty, holds zero, or holds a nonzero value. The tags gate every read, so an operation that touches an empty slot is refused, and a push into a slot that is still occupied is refused as well.

One command is accepted per clock. The commands are: clear, push a value, copy the top into another slot, copy and then pop, swap the top with another slot, and a two-operand integer operation. The operation is add, subtract, reverse subtract or multiply, and it comes in four forms: result to the top, result to the other slot, result to the other slot followed by a pop, and an implicit form with no register operand. The host sees the top value, the packed tags, the pointer, and one-cycle overflow and underflow flags. The block is meant to sit behind an instruction decoder that turns stack-machine instructions into these commands.

Top module: `stkreg_file`

## Requirements
- R1: After reset, and in the cycle after a clear command (cmd_op=1), every tag reads empty (tag_word all ones), top_ptr is 0 and both flags are 0.
- R2: A push (cmd_op=2) onto an empty slot moves top_ptr to top_ptr-1 modulo 8 and writes load_data into the new top. The tag of physical register n sits at tag_word[2n+1:2n], with 2'b00 for a nonzero value, 2'b01 for zero and 2'b11 for empty. The value 2'b10 is reserved and is never produced.
- R3: A push whose target slot is not empty raises overflow. It changes no data, no tag and no pointer.
- R4: A store (cmd_op=3) copies offset 0 into offset cmd_idx and sets that slot's tag from the value. The pointer does not move.
- R5: Store-and-pop (cmd_op=4) with cmd_idx other than 0 copies the top into offset cmd_idx, then tags the old top empty and moves top_ptr up by one modulo 8. With cmd_idx of 0 it only discards the top.
- R6: Exchange (cmd_op=5) swaps offset 0 with offset cmd_idx. When idx_default is 1, offset 1 is used and cmd_idx is ignored.
- R7: cmd_func selects the operation: 0 gives dst+src, 1 gives dst-src, 2 gives src-dst and 3 gives dst*src. Every result is taken modulo 2^32.
- R8: An arithmetic command (cmd_op=6) with cmd_form=1 computes offset0 <= offset0 op offset i. With cmd_form=2 it computes offset i <= offset i op offset0. Neither form moves the pointer.
- R9: cmd_form=3 computes offset i <= offset i op offset0 and then pops. cmd_form=0 ignores cmd_idx and behaves exactly like cmd_form=3 with i=1.
- R10: A command that reads an empty slot raises underflow. It makes no write, no tag change and no pointer move.
- R11: top_value reads 0 while the top slot is empty. overflow and underflow are valid in the cycle after the command and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_op | input | 3 | 0 idle, 1 clear, 2 push, 3 store, 4 store-and-pop, 5 exchange, 6 arithmetic |
| cmd_form | input | 2 | Arithmetic form: 0 implicit, 1 to top, 2 to offset, 3 to offset and pop |
| cmd_func | input | 2 | Arithmetic function: 0 add, 1 subtract, 2 reverse subtract, 3 multiply |
| cmd_idx | input | 3 | Register offset from the top |
| idx_default | input | 1 | Exchange uses offset 1 instead of cmd_idx |
| load_data | input | 32 | Value to push |
| top_value | output | 32 | Contents of offset 0, or 0 if it is empty |
| tag_word | output | 16 | Packed tags, two bits per physical register |
| top_ptr | output | 3 | Physical index of the top |
| overflow | output | 1 | Push was refused on an occupied slot |
| underflow | output | 1 | Command was refused on an empty operand |

## Verification
The bench builds the block with eight registers of 32 bits. With that depth, a run of eight pushes fills every slot and brings the pointer all the way round from 0 through 7 back to 0, so the ninth push is a true overflow. Popping past slot 7 exercises the wrap the other way. The 32-bit width makes the direction of subtraction visible, because a wrong operand order wraps to a different negative pattern. A zero-valued result is used to check the switch of the zero tag.

// File: rtl/stkreg_pkg.sv
package stkreg_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_INIT  = 3'd1,
    CMD_LOAD  = 3'd2,
    CMD_STORE = 3'd3,
    CMD_STPOP = 3'd4,
    CMD_XCHG  = 3'd5,
    CMD_ARITH = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    FORM_IMPL  = 2'd0,
    FORM_TOTOP = 2'd1,
    FORM_TOREG = 2'd2,
    FORM_POP   = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_SUB  = 2'd1,
    FN_SUBR = 2'd2,
    FN_MUL  = 2'd3
  } func_e;

  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;

  localparam int TAG_W = 2;

endpackage

// File: rtl/stkreg_alu.sv
module stkreg_alu
  import stkreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  func_e         func,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] res
);

  always_comb begin
    unique case (func)
      FN_ADD:  res = dst + src;
      FN_SUB:  res = dst - src;
      FN_SUBR: res = src - dst;
      default: res = dst * src;
    endcase
  end

endmodule

// File: rtl/stkreg_tagger.sv
module stkreg_tagger
  import stkreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] value,
  output tag_e          tag
);

  // special encoding is reserved: integer operands have no special class
  assign tag = (value == '0) ? TAG_ZERO : TAG_VALID;

endmodule

// File: rtl/stkreg_ctrl.sv
module stkreg_ctrl
  import stkreg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int PW  = $clog2(NREG)
) (
  input  cmd_e                             cmd,
  input  form_e                            form,
  input  func_e                            func,
  input  logic [PW-1:0]                    idx,
  input  logic                             idx_dflt,
  input  logic [DW-1:0]                    load_data,
  input  logic [PW-1:0]                    top_q,
  input  logic [NREG-1:0][TAG_W-1:0]       tags_q,
  input  logic [DW-1:0]                    regs_q [NREG],
  output logic                             wa_en,
  output logic [PW-1:0]                    wa_slot,
  output logic [DW-1:0]                    wa_data,
  output logic                             wb_en,
  output logic [PW-1:0]                    wb_slot,
  output logic [DW-1:0]                    wb_data,
  output logic                             pop_en,
  output logic                             init_en,
  output logic [PW-1:0]                    top_nxt,
  output logic                             ovf_nxt,
  output logic                             unf_nxt
);

  logic [PW-1:0] eff_idx;
  logic [PW-1:0] st0_slot;
  logic [PW-1:0] sti_slot;
  logic [PW-1:0] push_slot;
  logic [PW-1:0] pop_top;
  logic          st0_empty;
  logic          sti_empty;
  logic          push_busy;
  logic [DW-1:0] v0;
  logic [DW-1:0] vi;
  logic [DW-1:0] alu_dst;
  logic [DW-1:0] alu_src;
  logic [DW-1:0] alu_res;

  always_comb begin
    if ((cmd == CMD_XCHG && idx_dflt) || (cmd == CMD_ARITH && form == FORM_IMPL))
      eff_idx = PW'(1);
    else
      eff_idx = idx;
  end

  assign st0_slot  = top_q;
  assign sti_slot  = top_q + eff_idx;
  assign push_slot = top_q - PW'(1);
  assign pop_top   = top_q + PW'(1);
  assign st0_empty = (tags_q[st0_slot] == TAG_EMPTY);
  assign sti_empty = (tags_q[sti_slot] == TAG_EMPTY);
  assign push_busy = (tags_q[push_slot] != TAG_EMPTY);
  assign v0        = regs_q[st0_slot];
  assign vi        = regs_q[sti_slot];

  assign alu_dst = (form == FORM_TOTOP) ? v0 : vi;
  assign alu_src = (form == FORM_TOTOP) ? vi : v0;

  stkreg_alu #(.DW(DW)) alu_i (
    .func (func),
    .dst  (alu_dst),
    .src  (alu_src),
    .res  (alu_res)
  );

  always_comb begin
    wa_en   = 1'b0;
    wa_slot = st0_slot;
    wa_data = v0;
    wb_en   = 1'b0;
    wb_slot = sti_slot;
    wb_data = v0;
    pop_en  = 1'b0;
    init_en = 1'b0;
    top_nxt = top_q;
    ovf_nxt = 1'b0;
    unf_nxt = 1'b0;
    unique case (cmd)
      CMD_INIT: begin
        init_en = 1'b1;
        top_nxt = '0;
      end
      CMD_LOAD: begin
        if (push_busy) begin
          ovf_nxt = 1'b1;
        end else begin
          wa_en   = 1'b1;
          wa_slot = push_slot;
          wa_data = load_data;
          top_nxt = push_slot;
        end
      end
      CMD_STORE: begin
        if (st0_empty) begin
          unf_nxt = 1'b1;
        end else begin
          wa_en   = 1'b1;
          wa_slot = sti_slot;
          wa_data = v0;
        end
      end
      CMD_STPOP: begin
        if (st0_empty) begin
          unf_nxt = 1'b1;
        end else begin
          wa_en   = (eff_idx != '0);
          wa_slot = sti_slot;
          wa_data = v0;
          pop_en  = 1'b1;
          top_nxt = pop_top;
        end
      end
      CMD_XCHG: begin
        if (st0_empty || sti_empty) begin
          unf_nxt = 1'b1;
        end else begin
          wa_en   = 1'b1;
          wa_slot = st0_slot;
          wa_data = vi;
          wb_en   = 1'b1;
          wb_slot = sti_slot;
          wb_data = v0;
        end
      end
      CMD_ARITH: begin
        if (st0_empty || sti_empty) begin
          unf_nxt = 1'b1;
        end else begin
          wa_en   = 1'b1;
          wa_slot = (form == FORM_TOTOP) ? st0_slot : sti_slot;
          wa_data = alu_res;
          if (form == FORM_POP || form == FORM_IMPL) begin
            pop_en  = 1'b1;
            top_nxt = pop_top;
          end
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/stkreg_file.sv
module stkreg_file
  import stkreg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int PW  = $clog2(NREG),
  localparam int TWW = NREG * TAG_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     cmd_op,
  input  logic [1:0]     cmd_form,
  input  logic [1:0]     cmd_func,
  input  logic [PW-1:0]  cmd_idx,
  input  logic           idx_default,
  input  logic [DW-1:0]  load_data,
  output logic [DW-1:0]  top_value,
  output logic [TWW-1:0] tag_word,
  output logic [PW-1:0]  top_ptr,
  output logic           overflow,
  output logic           underflow
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // state
  logic [DW-1:0]              regs_q [NREG];
  logic [NREG-1:0][TAG_W-1:0] tags_q;
  logic [PW-1:0]              top_q;
  logic                       ovf_q;
  logic                       unf_q;

  // command decode
  logic          wa_en, wb_en, pop_en, init_en;
  logic [PW-1:0] wa_slot, wb_slot, top_nxt;
  logic [DW-1:0] wa_data, wb_data;
  logic          ovf_nxt, unf_nxt;

  stkreg_ctrl #(.NREG(NREG), .DW(DW)) ctrl_i (
    .cmd       (cmd_e'(cmd_op)),
    .form      (form_e'(cmd_form)),
    .func      (func_e'(cmd_func)),
    .idx       (cmd_idx),
    .idx_dflt  (idx_default),
    .load_data (load_data),
    .top_q     (top_q),
    .tags_q    (tags_q),
    .regs_q    (regs_q),
    .wa_en     (wa_en),
    .wa_slot   (wa_slot),
    .wa_data   (wa_data),
    .wb_en     (wb_en),
    .wb_slot   (wb_slot),
    .wb_data   (wb_data),
    .pop_en    (pop_en),
    .init_en   (init_en),
    .top_nxt   (top_nxt),
    .ovf_nxt   (ovf_nxt),
    .unf_nxt   (unf_nxt)
  );

  // per-register next state
  logic [NREG-1:0]            reg_we;
  logic [DW-1:0]              reg_d [NREG];
  logic [NREG-1:0]            tag_we;
  logic [NREG-1:0][TAG_W-1:0] tag_d;

  for (genvar n = 0; n < NREG; n++) begin : g_slot
    logic hit_a;
    logic hit_b;
    logic top_here;
    tag_e val_tag;

    assign hit_a    = wa_en && (wa_slot == PW'(n));
    assign hit_b    = wb_en && (wb_slot == PW'(n));
    assign top_here = (top_q == PW'(n));

    stkreg_tagger #(.DW(DW)) tagger_i (
      .value (reg_d[n]),
      .tag   (val_tag)
    );

    always_comb begin
      reg_we[n] = hit_a || hit_b;
      reg_d[n]  = hit_a ? wa_data : wb_data;
      tag_we[n] = init_en || reg_we[n] || (pop_en && top_here);
      if (init_en || (pop_en && top_here))
        tag_d[n] = TAG_EMPTY;
      else
        tag_d[n] = val_tag;
    end
  end

  // data registers carry no reset: the tags qualify them
  always_ff @(posedge clk) begin
    for (int n = 0; n < NREG; n++) begin
      if (reg_we[n]) regs_q[n] <= reg_d[n];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tags_q <= {NREG{TAG_EMPTY}};
    end else begin
      for (int n = 0; n < NREG; n++) begin
        if (tag_we[n]) tags_q[n] <= tag_d[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      top_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      top_q <= top_nxt;
      ovf_q <= ovf_nxt;
      unf_q <= unf_nxt;
    end
  end

  // outputs
  assign top_value = (tags_q[top_q] == TAG_EMPTY) ? '0 : regs_q[top_q];
  assign tag_word  = tags_q;
  assign top_ptr   = top_q;
  assign overflow  = ovf_q;
  assign underflow = unf_q;

endmodule

// File: rtl/stkreg_chk.sv
module stkreg_chk
  import stkreg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int PW  = $clog2(NREG),
  localparam int TWW = NREG * TAG_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     cmd_op,
  input logic [1:0]     cmd_form,
  input logic [DW-1:0]  load_data,
  input logic [DW-1:0]  top_value,
  input logic [TWW-1:0] tag_word,
  input logic [PW-1:0]  top_ptr,
  input logic           overflow,
  input logic           underflow
);

  logic [PW-1:0]    push_slot;
  logic [PW-1:0]    next_slot;
  logic [TAG_W-1:0] push_tag;
  logic [TAG_W-1:0] top_tag;
  logic [TAG_W-1:0] next_tag;

  assign push_slot = top_ptr - PW'(1);
  assign next_slot = top_ptr + PW'(1);
  assign push_tag  = tag_word[TAG_W*push_slot +: TAG_W];
  assign top_tag   = tag_word[TAG_W*top_ptr +: TAG_W];
  assign next_tag  = tag_word[TAG_W*next_slot +: TAG_W];

  // R1
  init_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_INIT) |=> (tag_word == '1 && top_ptr == '0));

  // R2
  push_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_LOAD && push_tag == TAG_EMPTY)
      |=> (top_ptr == $past(push_slot) && top_value == $past(load_data) && !overflow));

  // R3
  no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_LOAD && push_tag != TAG_EMPTY)
      |=> (overflow && $stable(top_ptr) && $stable(tag_word)));

  // R9
  implicit_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == CMD_ARITH && cmd_form == FORM_IMPL && top_tag != TAG_EMPTY && next_tag != TAG_EMPTY)
      |=> (top_ptr == $past(next_slot) && !underflow));

  // R10
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> (top_ptr == $past(top_ptr) && tag_word == $past(tag_word)));

  // R11
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(overflow && underflow));

  // R11
  empty_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_tag == TAG_EMPTY) |-> (top_value == '0));

endmodule

bind stkreg_file stkreg_chk #(.NREG(NREG), .DW(DW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_op    (cmd_op),
  .cmd_form  (cmd_form),
  .load_data (load_data),
  .top_value (top_value),
  .tag_word  (tag_word),
  .top_ptr   (top_ptr),
  .overflow  (overflow),
  .underflow (underflow)
);

// File: tb/stkreg_file_tb_top.sv
module stkreg_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [1:0]  cmd_form = 2'd0;
  logic [1:0]  cmd_func = 2'd0;
  logic [2:0]  cmd_idx = 3'd0;
  logic        idx_default = 1'b0;
  logic [31:0] load_data = 32'd0;
  logic [31:0] top_value;
  logic [15:0] tag_word;
  logic [2:0]  top_ptr;
  logic        overflow;
  logic        underflow;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  stkreg_file dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_op      (cmd_op),
    .cmd_form    (cmd_form),
    .cmd_func    (cmd_func),
    .cmd_idx     (cmd_idx),
    .idx_default (idx_default),
    .load_data   (load_data),
    .top_value   (top_value),
    .tag_word    (tag_word),
    .top_ptr     (top_ptr),
    .overflow    (overflow),
    .underflow   (underflow)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [31:0] tv,
                             input logic [15:0] tw, input logic [2:0] tp);
    check(req, "top_value", top_value, tv);
    check(req, "tag_word", {16'd0, tag_word}, {16'd0, tw});
    check(req, "top_ptr", {29'd0, top_ptr}, {29'd0, tp});
  endtask

  // drive on falling edge, executes on rising edge, sampled on next falling edge
  task automatic issue(input logic [2:0] op, input logic [1:0] form, input logic [1:0] fn,
                       input logic [2:0] idx, input logic dflt, input logic [31:0] d);
    @(negedge clk);
    cmd_op = op; cmd_form = form; cmd_func = fn;
    cmd_idx = idx; idx_default = dflt; load_data = d;
    @(posedge clk);
    @(negedge clk);
    cmd_op = 3'd0; cmd_idx = 3'd0; idx_default = 1'b0; load_data = 32'd0;
  endtask

  task automatic do_init();                     issue(3'd1, 2'd0, 2'd0, 3'd0, 1'b0, 32'd0); endtask
  task automatic do_load(input logic [31:0] d); issue(3'd2, 2'd0, 2'd0, 3'd0, 1'b0, d);     endtask
  task automatic do_stpop(input logic [2:0] i); issue(3'd4, 2'd0, 2'd0, i, 1'b0, 32'd0);    endtask

  task automatic t_reset();
    check_state("R1", 32'd0, 16'hFFFF, 3'd0);
    check("R1", "overflow", {31'd0, overflow}, 32'd0);
    check("R1", "underflow", {31'd0, underflow}, 32'd0);
  endtask

  task automatic t_push_pop();
    do_load(32'd5);
    check_state("R2", 32'd5, 16'h3FFF, 3'd7);
    do_load(32'd0);
    check_state("R2", 32'd0, 16'h1FFF, 3'd6);
    do_stpop(3'd0);
    check_state("R5", 32'd5, 16'h3FFF, 3'd7);
    do_stpop(3'd0);
    check_state("R11", 32'd0, 16'hFFFF, 3'd0);
  endtask

  task automatic t_arith_forms();
    do_load(32'd10);
    do_load(32'd3);
    do_init();
    check_state("R1", 32'd0, 16'hFFFF, 3'd0);
    do_load(32'd10);
    do_load(32'd3);
    issue(3'd6, 2'd1, 2'd1, 3'd1, 1'b0, 32'd0);   // top <= 3 - 10
    check_state("R8", 32'hFFFF_FFF9, 16'h0FFF, 3'd6);
    issue(3'd6, 2'd2, 2'd2, 3'd1, 1'b0, 32'd0);   // ST(1) <= -7 - 10
    check_state("R8", 32'hFFFF_FFF9, 16'h0FFF, 3'd6);
    issue(3'd6, 2'd0, 2'd0, 3'd5, 1'b0, 32'd0);   // implicit add, idx ignored
    check_state("R9", 32'hFFFF_FFE8, 16'h3FFF, 3'd7);
  endtask

  task automatic t_mul_pop();
    do_init();
    do_load(32'd6);
    do_load(32'd7);
    do_load(32'd2);
    issue(3'd6, 2'd3, 2'd3, 3'd2, 1'b0, 32'd0);   // ST(2) <= 6 * 2, pop
    check_state("R9", 32'd7, 16'h0FFF, 3'd6);
    do_stpop(3'd0);
    check_state("R7", 32'd12, 16'h3FFF, 3'd7);
    do_load(32'd12);
    issue(3'd6, 2'd0, 2'd1, 3'd0, 1'b0, 32'd0);   // 12 - 12, zero tag
    check_state("R7", 32'd0, 16'h7FFF, 3'd7);
  endtask

  task automatic t_store();
    do_init();
    do_load(32'd4);
    do_load(32'd9);
    issue(3'd3, 2'd0, 2'd0, 3'd3, 1'b0, 32'd0);   // phys 1 <= 9
    check_state("R4", 32'd9, 16'h0FF3, 3'd6);
    do_stpop(3'd1);                                // phys 7 <= 9, pop
    check_state("R5", 32'd9, 16'h3FF3, 3'd7);
    do_stpop(3'd0);
    check_state("R5", 32'd0, 16'hFFF3, 3'd0);
    do_stpop(3'd0);                                // top empty
    check("R10", "underflow", {31'd0, underflow}, 32'd1);
    check_state("R10", 32'd0, 16'hFFF3, 3'd0);
  endtask

  task automatic t_xchg();
    do_init();
    do_load(32'd1);
    do_load(32'd2);
    do_load(32'd3);
    issue(3'd5, 2'd0, 2'd0, 3'd4, 1'b1, 32'd0);   // default offset 1
    check_state("R6", 32'd2, 16'h03FF, 3'd5);
    issue(3'd5, 2'd0, 2'd0, 3'd2, 1'b0, 32'd0);
    check_state("R6", 32'd1, 16'h03FF, 3'd5);
    do_stpop(3'd0);
    check("R6", "second", top_value, 32'd3);
    do_stpop(3'd0);
    check("R6", "third", top_value, 32'd2);
  endtask

  task automatic t_overflow();
    do_init();
    for (int k = 1; k <= 8; k++) do_load(32'(k));
    check_state("R2", 32'd8, 16'h0000, 3'd0);
    do_load(32'd99);
    check("R3", "overflow", {31'd0, overflow}, 32'd1);
    check_state("R3", 32'd8, 16'h0000, 3'd0);
    issue(3'd0, 2'd0, 2'd0, 3'd0, 1'b0, 32'd0);
    check("R11", "overflow pulse", {31'd0, overflow}, 32'd0);
  endtask

  task automatic t_underflow();
    do_init();
    do_load(32'd5);
    issue(3'd6, 2'd1, 2'd0, 3'd1, 1'b0, 32'd0);
    check("R10", "underflow to-top", {31'd0, underflow}, 32'd1);
    check_state("R10", 32'd5, 16'h3FFF, 3'd7);
    issue(3'd6, 2'd0, 2'd0, 3'd0, 1'b0, 32'd0);
    check("R10", "underflow implicit", {31'd0, underflow}, 32'd1);
    check_state("R10", 32'd5, 16'h3FFF, 3'd7);
    issue(3'd5, 2'd0, 2'd0, 3'd0, 1'b1, 32'd0);
    check("R10", "underflow exchange", {31'd0, underflow}, 32'd1);
    check("R11", "no overflow", {31'd0, overflow}, 32'd0);
    do_init();
    issue(3'd3, 2'd0, 2'd0, 3'd2, 1'b0, 32'd0);
    check("R10", "underflow store", {31'd0, underflow}, 32'd1);
    check_state("R10", 32'd0, 16'hFFFF, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push_pop();
    t_arith_forms();
    t_mul_pop();
    t_store();
    t_xchg();
    t_overflow();
    t_underflow();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule